// File: doc/BRIEF.md
# Cache Fill Register Writeback Unit

This unit sits between the returning cache-line fill path and the two register files. A line fill arrives as two beats, and each beat carries two 64-bit quadwords. For every quadword of the line, the unit holds a small miss record: a valid bit, a destination register number, a bit selecting the integer or floating-point file, a size bit (longword or quadword), and a bit giving which 32-bit half a longword load addressed. The miss allocator elsewhere writes these records through a simple record write port.

When a beat arrives, each quadword slot of the beat drives its own write port. The slot's write port raises a request only if that quadword's record is valid. The data is formatted first. A quadword load passes through unchanged. An integer longword is sign-extended from the addressed half. A floating longword is zero-extended. The record is cleared once its quadword has been written. A completion pulse follows the last beat of the line. Because merging leaves at most one register per quadword, two write ports are enough, and each port always serves the same slot position within a beat.

Top module: `fill_wb_unit`

## Requirements
- R1: After reset, no write port is valid, `fill_done` is low, and every miss record is invalid, so a fill that arrives before any record is loaded produces no write.
- R2: A fill beat with index b on `fill_beat` serves quadwords 2b and 2b+1 of the line. Quadword 2b+p drives write port p, and the request appears in the cycle after the beat is presented. Each quadword is bits [64q+63:64q] of `fill_data`, where q is its position within the beat.
- R3: A write port whose quadword has no valid record raises no request. While a port is idle, its data, register number and file select are zero.
- R4: A request carries the register number of the record and its file select (1 = floating-point, 0 = integer).
- R5: For a record with the size bit at 0 (quadword), the write data equals the 64-bit quadword unchanged.
- R6: For an integer record with the size bit at 1 (longword), the write data is the selected 32-bit half, sign-extended to 64 bits. The half-select bit at 1 picks bits 63:32, and at 0 it picks bits 31:0.
- R7: For a floating-point longword record, the write data is the selected 32-bit half, zero-extended to 64 bits. The half is selected as in R6.
- R8: A record is invalidated when its quadword is written, so presenting the same beat again produces no request.
- R9: `fill_done` is high for exactly the cycle after a beat with the last index (1) is presented, and is low otherwise.
- R10: A cycle with `fill_valid` low raises no request and leaves all records intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_we | input | 1 | Load a miss record (sets it valid) |
| rec_idx | input | 2 | Quadword index of the record within the line |
| rec_reg | input | REG_W | Destination register number |
| rec_fp | input | 1 | 1 = floating-point file, 0 = integer file |
| rec_lw | input | 1 | 1 = longword load, 0 = quadword load |
| rec_hi | input | 1 | Longword half select: 1 = upper 32 bits |
| fill_valid | input | 1 | Fill beat present this cycle |
| fill_beat | input | 1 | Beat index within the line |
| fill_data | input | PORTS*64 | Two quadwords; slot p in bits [64p+63:64p] |
| wp_vld | output | PORTS | Write request per port |
| wp_fp | output | PORTS | File select per port |
| wp_reg | output | PORTS*REG_W | Register number per port |
| wp_data | output | PORTS*64 | Formatted write data per port |
| fill_done | output | 1 | Line fill complete pulse |

## Verification
A wrong record bit becomes visible at the ports in the cycle after the beat that reads it. A record that was never cleared shows up as a second request when a beat repeats. A record that was lost shows up as a missing request. A wrong file select or half select shows up as wrong data or a wrong file bit on that same cycle. The sweep covers every pattern of valid records across the four quadwords, combined with every mix of file, size and half bits. Each case then replays beat 0, so a stale record is exposed within two cycles of the line completing.

// File: rtl/fill_wb_pkg.sv
package fill_wb_pkg;
    localparam int QWORD_W = 64;
    localparam int LWORD_W = 32;
endpackage

// File: rtl/fill_wb_fmt.sv
module fill_wb_fmt
    import fill_wb_pkg::*;
(
    input  logic               is_lw,
    input  logic               is_fp,
    input  logic               upper,
    input  logic [QWORD_W-1:0] qword,
    output logic [QWORD_W-1:0] result
);
    logic [LWORD_W-1:0] half;

    always_comb begin
        half = upper ? qword[QWORD_W-1:LWORD_W] : qword[LWORD_W-1:0];
        if (!is_lw)
            result = qword;
        else if (is_fp)
            result = {{(QWORD_W-LWORD_W){1'b0}}, half};
        else
            result = {{(QWORD_W-LWORD_W){half[LWORD_W-1]}}, half};
    end
endmodule

// File: rtl/fill_wb_slot.sv
module fill_wb_slot
    import fill_wb_pkg::*;
(
    input  logic               beat_on,
    input  logic               rec_vld,
    input  logic               rec_fp,
    input  logic               rec_lw,
    input  logic               rec_hi,
    input  logic [QWORD_W-1:0] qword,
    output logic               hit,
    output logic [QWORD_W-1:0] fmt_data
);
    logic [QWORD_W-1:0] shaped;

    fill_wb_fmt u_fmt (
        .is_lw  (rec_lw),
        .is_fp  (rec_fp),
        .upper  (rec_hi),
        .qword  (qword),
        .result (shaped)
    );

    assign hit      = beat_on & rec_vld;
    assign fmt_data = hit ? shaped : '0;
endmodule

// File: rtl/fill_wb_unit.sv
module fill_wb_unit
    import fill_wb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int PORTS = 2,
    parameter int BEATS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rec_we,
    input  logic [$clog2(PORTS*BEATS)-1:0]    rec_idx,
    input  logic [REG_W-1:0]                  rec_reg,
    input  logic                              rec_fp,
    input  logic                              rec_lw,
    input  logic                              rec_hi,
    input  logic                              fill_valid,
    input  logic [$clog2(BEATS)-1:0]          fill_beat,
    input  logic [PORTS*QWORD_W-1:0]          fill_data,
    output logic [PORTS-1:0]                  wp_vld,
    output logic [PORTS-1:0]                  wp_fp,
    output logic [PORTS*REG_W-1:0]            wp_reg,
    output logic [PORTS*QWORD_W-1:0]          wp_data,
    output logic                              fill_done
);
    localparam int NQ     = PORTS * BEATS;
    localparam int IDX_W  = $clog2(NQ);
    localparam int BEAT_W = $clog2(BEATS);

    typedef struct packed {
        logic             vld;
        logic             fp;
        logic             lw;
        logic             hi;
        logic [REG_W-1:0] rnum;
    } rec_t;

    typedef struct packed {
        rec_t [NQ-1:0]                  rec;
        logic [PORTS-1:0]               wv;
        logic [PORTS-1:0]               wf;
        logic [PORTS-1:0][REG_W-1:0]    wr;
        logic [PORTS-1:0][QWORD_W-1:0]  wd;
        logic                           done;
    } st_t;

    st_t s_d, s_q;

    logic [PORTS-1:0][IDX_W-1:0]   qidx;
    rec_t [PORTS-1:0]              cur;
    logic [PORTS-1:0]              hit;
    logic [PORTS-1:0][QWORD_W-1:0] fdat;

    for (genvar p = 0; p < PORTS; p++) begin : g_slot
        assign qidx[p] = IDX_W'(fill_beat) * IDX_W'(PORTS) + IDX_W'(p);
        assign cur[p]  = s_q.rec[qidx[p]];

        fill_wb_slot u_slot (
            .beat_on  (fill_valid),
            .rec_vld  (cur[p].vld),
            .rec_fp   (cur[p].fp),
            .rec_lw   (cur[p].lw),
            .rec_hi   (cur[p].hi),
            .qword    (fill_data[p*QWORD_W +: QWORD_W]),
            .hit      (hit[p]),
            .fmt_data (fdat[p])
        );

        assign wp_vld[p]                     = s_q.wv[p];
        assign wp_fp[p]                      = s_q.wf[p];
        assign wp_reg[p*REG_W +: REG_W]      = s_q.wr[p];
        assign wp_data[p*QWORD_W +: QWORD_W] = s_q.wd[p];
    end

    assign fill_done = s_q.done;

    always_comb begin
        s_d      = s_q;
        s_d.done = fill_valid && (fill_beat == BEAT_W'(BEATS - 1));
        for (int p = 0; p < PORTS; p++) begin
            s_d.wv[p] = hit[p];
            s_d.wf[p] = hit[p] & cur[p].fp;
            s_d.wr[p] = hit[p] ? cur[p].rnum : '0;
            s_d.wd[p] = fdat[p];
            if (hit[p])
                s_d.rec[qidx[p]].vld = 1'b0;
        end
        if (rec_we) begin
            s_d.rec[rec_idx].vld  = 1'b1;
            s_d.rec[rec_idx].fp   = rec_fp;
            s_d.rec[rec_idx].lw   = rec_lw;
            s_d.rec[rec_idx].hi   = rec_hi;
            s_d.rec[rec_idx].rnum = rec_reg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end
endmodule

// File: rtl/fill_wb_chk.sv
module fill_wb_chk
    import fill_wb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int PORTS = 2,
    parameter int BEATS = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fill_valid,
    input logic [$clog2(BEATS)-1:0] fill_beat,
    input logic [PORTS-1:0]         wp_vld,
    input logic [PORTS-1:0]         wp_fp,
    input logic [PORTS*REG_W-1:0]   wp_reg,
    input logic [PORTS*QWORD_W-1:0] wp_data,
    input logic                     fill_done
);
    localparam int BEAT_W = $clog2(BEATS);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (wp_vld == '0) && !fill_done);

    // R2
    req_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wp_vld) |-> $past(fill_valid));

    // R9
    done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> $past(fill_valid && (fill_beat == BEAT_W'(BEATS - 1))));

    // R9
    last_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_valid && (fill_beat == BEAT_W'(BEATS - 1))) |-> fill_done);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        // R3
        idle_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wp_vld[p] |-> (wp_data[p*QWORD_W +: QWORD_W] == '0)
                        && (wp_reg[p*REG_W +: REG_W] == '0) && !wp_fp[p]);
    end
endmodule

bind fill_wb_unit fill_wb_chk #(
    .REG_W (REG_W),
    .PORTS (PORTS),
    .BEATS (BEATS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .fill_beat  (fill_beat),
    .wp_vld     (wp_vld),
    .wp_fp      (wp_fp),
    .wp_reg     (wp_reg),
    .wp_data    (wp_data),
    .fill_done  (fill_done)
);

// File: tb/sim_fill_wb_unit.sv
module sim_fill_wb_unit;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 5;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rec_we;
    logic [1:0]   rec_idx;
    logic [4:0]   rec_reg;
    logic         rec_fp, rec_lw, rec_hi;
    logic         fill_valid;
    logic [0:0]   fill_beat;
    logic [127:0] fill_data;
    logic [1:0]   wp_vld, wp_fp;
    logic [9:0]   wp_reg;
    logic [127:0] wp_data;
    logic         fill_done;

    int n_chk  = 0;
    int n_fail = 0;

    logic       e_v  [4];
    logic       e_fp [4];
    logic       e_lw [4];
    logic       e_hi [4];
    logic [4:0] e_rg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    fill_wb_unit #(.REG_W(REG_W), .PORTS(2), .BEATS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .rec_we(rec_we), .rec_idx(rec_idx),
        .rec_reg(rec_reg), .rec_fp(rec_fp), .rec_lw(rec_lw), .rec_hi(rec_hi),
        .fill_valid(fill_valid), .fill_beat(fill_beat), .fill_data(fill_data),
        .wp_vld(wp_vld), .wp_fp(wp_fp), .wp_reg(wp_reg), .wp_data(wp_data),
        .fill_done(fill_done)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] mkq(input int k, input int seed);
        logic [30:0] a, b;
        a = 31'(32'h0765_4300 + k * 3 + seed);
        b = 31'(32'h0234_5600 + k + seed * 5);
        return {1'(seed >> 1) ^ 1'(k), a, 1'(seed) ^ 1'(k >> 1), b};
    endfunction

    function automatic logic [63:0] shape(input logic [63:0] q, input logic fp,
                                          input logic lw, input logic hi);
        logic [31:0] h;
        h = hi ? q[63:32] : q[31:0];
        if (!lw)     return q;
        else if (fp) return {32'h0, h};
        else         return {{32{h[31]}}, h};
    endfunction

    task automatic check_beat(input int b, input logic [127:0] dat);
        for (int p = 0; p < 2; p++) begin
            int k;
            string rq;
            k = b * 2 + p;
            chk("R2/R3 request", 64'(wp_vld[p]), 64'(e_v[k]));
            if (e_v[k]) begin
                chk("R4 file", 64'(wp_fp[p]), 64'(e_fp[k]));
                chk("R4 register", 64'(wp_reg[p*5 +: 5]), 64'(e_rg[k]));
                rq = !e_lw[k] ? "R5 quadword data" : (e_fp[k] ? "R7 float longword" : "R6 int longword");
                chk(rq, wp_data[p*64 +: 64],
                    shape(dat[p*64 +: 64], e_fp[k], e_lw[k], e_hi[k]));
            end else begin
                chk("R3 idle data", wp_data[p*64 +: 64], 64'h0);
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [127:0] d0, d1;
        rst_n = 1'b0; rec_we = 1'b0; rec_idx = '0; rec_reg = '0;
        rec_fp = 1'b0; rec_lw = 1'b0; rec_hi = 1'b0;
        fill_valid = 1'b0; fill_beat = '0; fill_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset valid", 64'(wp_vld), 64'h0);
        chk("R1 reset done", 64'(fill_done), 64'h0);
        fill_valid = 1'b1; fill_beat = 1'b0; fill_data = {mkq(1, 9), mkq(0, 9)};
        @(negedge clk);
        chk("R1 no record beat0", 64'(wp_vld), 64'h0);
        fill_beat = 1'b1; fill_data = {mkq(3, 9), mkq(2, 9)};
        @(negedge clk);
        chk("R1 no record beat1", 64'(wp_vld), 64'h0);
        fill_valid = 1'b0;
        @(negedge clk);

        for (int mask = 0; mask < 16; mask++) begin
            for (int fmt = 0; fmt < 8; fmt++) begin
                int seed;
                seed = mask * 8 + fmt;
                for (int k = 0; k < 4; k++) begin
                    e_v[k]  = 1'(mask >> k);
                    e_fp[k] = 1'(fmt) ^ 1'(k);
                    e_lw[k] = 1'(fmt >> 1);
                    e_hi[k] = 1'(fmt >> 2) ^ 1'(k >> 1);
                    e_rg[k] = 5'(mask * 4 + k + fmt);
                    if (e_v[k]) begin
                        rec_we = 1'b1; rec_idx = 2'(k); rec_reg = e_rg[k];
                        rec_fp = e_fp[k]; rec_lw = e_lw[k]; rec_hi = e_hi[k];
                        @(negedge clk);
                    end
                end
                rec_we = 1'b0;
                @(negedge clk);
                chk("R10 idle no request", 64'(wp_vld), 64'h0);
                d0 = {mkq(1, seed), mkq(0, seed)};
                d1 = {mkq(3, seed), mkq(2, seed)};
                fill_valid = 1'b1; fill_beat = 1'b0; fill_data = d0;
                @(negedge clk);
                check_beat(0, d0);
                chk("R9 no done after beat0", 64'(fill_done), 64'h0);
                fill_beat = 1'b1; fill_data = d1;
                @(negedge clk);
                check_beat(1, d1);
                chk("R9 done after last beat", 64'(fill_done), 64'h1);
                fill_valid = 1'b0;
                @(negedge clk);
                chk("R9 done one cycle", 64'(fill_done), 64'h0);
                chk("R10 no request when idle", 64'(wp_vld), 64'h0);
                fill_valid = 1'b1; fill_beat = 1'b0; fill_data = d0;
                @(negedge clk);
                chk("R8 record cleared", 64'(wp_vld), 64'h0);
                fill_valid = 1'b0;
                @(negedge clk);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule